// File: doc/BRIEF.md
# ATA PIO Host Cycle Engine

This block is a memory-mapped host controller that performs programmed-I/O register and data cycles on a parallel ATA or CompactFlash True-IDE bus. A CPU talks to it through a simple single-cycle register port. The port holds an enable, a configuration word, a packed timing word, interrupt status and mask registers, a busy status word and a read-data register. It also holds nine device windows.

A CPU write to a window queues one device write cycle. A CPU read of a window returns zero and queues one device read cycle. The captured device value is fetched later from the read-data register. Software polls a busy count and issues the next access only when that count reads zero.

The cycle engine drives the two active-low chip selects, the 3-bit device address, the read and write strobes and the 16-bit data bus. Each access has three phases: a setup phase with the address and chip select valid, an active phase with the strobe low, and an idle recovery phase. Each phase lasts a programmed number of clock cycles. When enabled, the device's ready line can stretch the active phase. A one-entry buffer holds a second access while the first is in flight.

Top module: `ata_pio_host`

## Requirements
- R1: After reset, both strobes and both chip selects are high, the data drive enable is low, irq is low, the busy field reads 0 and the read-data register (offset 0x18) reads 0.
- R2: The timing register at offset 0x08 holds the setup count in bits [3:0], the active count in bits [11:4] and the recovery count in bits [19:12], and it reads back only those 20 bits. An access keeps its chip select for exactly setup cycles before the strobe, holds the strobe low for exactly active cycles, and then takes exactly recovery cycles before the busy count drops. A programmed count of 0 behaves as 1.
- R3: Windows sit at offset 0x40 + 4k. For k = 0..7 the cycle asserts cs0_n with device address k (k=0 is the data register, k=7 is command/status). Window k = 8 asserts cs1_n with device address 6 (device control / alternate status). Exactly one chip select is low whenever a strobe is low.
- R4: A write through window 1..8 drives cpu_wdata[7:0] on the low byte and zero on the high byte. A write through window 0 drives cpu_wdata[15:0]. The data drive enable is high only during the setup and active phases of write cycles. The read and write strobes are never low together.
- R5: A CPU read of a window returns 0 on cpu_rdata and starts a device read cycle. The device data at the end of the active phase appears in read-data bits [15:0]: all 16 bits for window 0, and bits [7:0] zero-extended for the others.
- R6: Configuration (offset 0x04) bit 6 swaps the two bytes of window-0 data in both directions. Byte windows are not affected.
- R7: Configuration bit 1 enables ready handling. When it is set, the active phase continues past its count while the synchronized ready input is low. When it is clear, a low ready input does not change the active length.
- R8: While control (offset 0x00) bit 0 is clear, no new cycle starts and queued accesses wait. Setting the bit starts them.
- R9: Status (offset 0x14) bits [31:28] give the number of queued and in-flight accesses. The value is never above 2. It is zero only when both strobes and both chip selects are high.
- R10: A second access that arrives while one is pending is buffered and runs after the first, in arrival order. An access that arrives with both slots full is discarded.
- R11: A rising edge of the device interrupt input, after a two-flop synchronizer, sets interrupt status bit 0 (offset 0x0C). Writing 1 to that bit clears it. A level that stays high does not set it again.
- R12: irq is high exactly when interrupt status bit 0 and mask (offset 0x10) bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Single-cycle CPU access strobe |
| cpu_wr | input | 1 | 1 for a write access, 0 for a read |
| cpu_addr | input | 8 | Byte offset of the register |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid in the access cycle |
| irq | output | 1 | Masked interrupt to the CPU |
| ata_cs0_n | output | 1 | Command block chip select, active low |
| ata_cs1_n | output | 1 | Control block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_o | output | 16 | Device data out |
| ata_dd_oe | output | 1 | Device data drive enable |
| ata_dd_i | input | 16 | Device data in |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |
| ata_intrq | input | 1 | Device interrupt request |

## Verification
The checker watches these rules on every clock: the strobes are never low together, a strobe low always has exactly one chip select low, the data bus is never driven while the read strobe is low, the busy count stays at or below 2, a zero busy count means the bus is quiet, and a chip select only falls after a cycle where the interface was enabled. The directed scenarios show what needs known stimulus: the exact phase lengths for several timing words, window-to-address mapping, byte and word data formatting, byte swapping, read-data capture, ready stretching, queue order and discard, and interrupt set, clear and masking.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int DEV_W   = 16;
  localparam int CPU_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int SETUP_W = 4;
  localparam int ACT_W   = 8;
  localparam int REC_W   = 8;
  localparam int CNT_W   = 8;
  localparam int BUSY_W  = 4;
  localparam int SYNC_N  = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_TIME  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RDAT  = 8'h18;
  localparam logic [1:0]        WIN_PAGE  = 2'b01;
  localparam logic [3:0]        WIN_LAST  = 4'd8;
  localparam logic [2:0]        ALT_DA    = 3'd6;

  localparam int CFG_RDY_BIT  = 1;
  localparam int CFG_SWAP_BIT = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOVER} phase_t;

  typedef struct packed {
    logic             rd;
    logic             wide;
    logic             alt;
    logic [2:0]       da;
    logic [DEV_W-1:0] wd;
  } acc_t;
endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
  import ata_pio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_sel,
  input  logic                cpu_wr,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [CPU_W-1:0]    cpu_wdata,
  output logic [CPU_W-1:0]    cpu_rdata,
  input  logic                intrq_s,
  input  logic                done,
  input  logic                cap_valid,
  input  logic [DEV_W-1:0]    cap_data,
  output logic                go,
  output acc_t                head,
  output logic [SETUP_W-1:0]  t_setup,
  output logic [ACT_W-1:0]    t_act,
  output logic [REC_W-1:0]    t_rec,
  output logic                rdy_en,
  output logic                swap_en,
  output logic                en,
  output logic [BUSY_W-1:0]   busy_cnt,
  output logic                irq
);
  localparam int TIME_W = SETUP_W + ACT_W + REC_W;

  logic               en_q, en_d, rdy_q, rdy_d, swap_q, swap_d;
  logic [TIME_W-1:0]  time_q, time_d;
  logic               istat_q, istat_d, imask_q, imask_d, intrq_prev_q;
  logic [DEV_W-1:0]   rdat_q, rdat_d;
  logic               hv_q, hv_d, pv_q, pv_d;
  acc_t               head_q, head_d, pend_q, pend_d, incoming;
  logic               win_hit, accept, rise;
  logic [3:0]         win_idx;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[CPU_W-1:TIME_W];
  assign win_idx = cpu_addr[5:2];
  assign win_hit = (cpu_addr[7:6] == WIN_PAGE) && (win_idx <= WIN_LAST) &&
                   (cpu_addr[1:0] == 2'b00);
  assign accept  = cpu_sel && win_hit;
  assign rise    = intrq_s && !intrq_prev_q;

  always_comb begin
    incoming.rd   = !cpu_wr;
    incoming.wide = (win_idx == 4'd0);
    incoming.alt  = (win_idx == WIN_LAST);
    incoming.da   = incoming.alt ? ALT_DA : win_idx[2:0];
    incoming.wd   = incoming.wide ? cpu_wdata[DEV_W-1:0]
                                  : {{(DEV_W-8){1'b0}}, cpu_wdata[7:0]};
  end

  always_comb begin
    en_d    = en_q;
    rdy_d   = rdy_q;
    swap_d  = swap_q;
    time_d  = time_q;
    imask_d = imask_q;
    istat_d = istat_q | rise;
    rdat_d  = rdat_q;
    hv_d    = hv_q;
    head_d  = head_q;
    pv_d    = pv_q;
    pend_d  = pend_q;
    if (cpu_sel && cpu_wr) begin
      case (cpu_addr)
        OFS_CTRL:  en_d = cpu_wdata[0];
        OFS_CFG: begin
          rdy_d  = cpu_wdata[CFG_RDY_BIT];
          swap_d = cpu_wdata[CFG_SWAP_BIT];
        end
        OFS_TIME:  time_d  = cpu_wdata[TIME_W-1:0];
        OFS_ISTAT: istat_d = (istat_q && !cpu_wdata[0]) || rise;
        OFS_IMASK: imask_d = cpu_wdata[0];
        default: ;
      endcase
    end
    if (cap_valid) rdat_d = cap_data;
    if (done) begin
      hv_d   = pv_q;
      head_d = pend_q;
      pv_d   = 1'b0;
    end
    if (accept) begin
      if (!hv_d) begin
        hv_d   = 1'b1;
        head_d = incoming;
      end else if (!pv_d) begin
        pv_d   = 1'b1;
        pend_d = incoming;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      rdy_q        <= 1'b0;
      swap_q       <= 1'b0;
      time_q       <= '0;
      istat_q      <= 1'b0;
      imask_q      <= 1'b0;
      intrq_prev_q <= 1'b0;
      rdat_q       <= '0;
      hv_q         <= 1'b0;
      head_q       <= '0;
      pv_q         <= 1'b0;
      pend_q       <= '0;
    end else begin
      en_q         <= en_d;
      rdy_q        <= rdy_d;
      swap_q       <= swap_d;
      time_q       <= time_d;
      istat_q      <= istat_d;
      imask_q      <= imask_d;
      intrq_prev_q <= intrq_s;
      rdat_q       <= rdat_d;
      hv_q         <= hv_d;
      head_q       <= head_d;
      pv_q         <= pv_d;
      pend_q       <= pend_d;
    end
  end

  assign busy_cnt = BUSY_W'(hv_q) + BUSY_W'(pv_q);

  always_comb begin
    cpu_rdata = '0;
    if (cpu_sel && !cpu_wr) begin
      case (cpu_addr)
        OFS_CTRL:  cpu_rdata[0] = en_q;
        OFS_CFG: begin
          cpu_rdata[CFG_RDY_BIT]  = rdy_q;
          cpu_rdata[CFG_SWAP_BIT] = swap_q;
        end
        OFS_TIME:  cpu_rdata[TIME_W-1:0] = time_q;
        OFS_ISTAT: cpu_rdata[0] = istat_q;
        OFS_IMASK: cpu_rdata[0] = imask_q;
        OFS_STAT:  cpu_rdata[CPU_W-1:CPU_W-BUSY_W] = busy_cnt;
        OFS_RDAT:  cpu_rdata[DEV_W-1:0] = rdat_q;
        default: ;
      endcase
    end
  end

  assign go      = hv_q && en_q;
  assign head    = head_q;
  assign t_setup = time_q[SETUP_W-1:0];
  assign t_act   = time_q[SETUP_W +: ACT_W];
  assign t_rec   = time_q[SETUP_W+ACT_W +: REC_W];
  assign rdy_en  = rdy_q;
  assign swap_en = swap_q;
  assign en      = en_q;
  assign irq     = istat_q && imask_q;
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  acc_t               head,
  input  logic [SETUP_W-1:0] t_setup,
  input  logic [ACT_W-1:0]   t_act,
  input  logic [REC_W-1:0]   t_rec,
  input  logic               rdy_en,
  input  logic               swap_en,
  input  logic               iordy_s,
  input  logic [DEV_W-1:0]   dd_i,
  output logic               done,
  output logic               cap_valid,
  output logic [DEV_W-1:0]   cap_data,
  output logic               cs0_n,
  output logic               cs1_n,
  output logic [2:0]         da,
  output logic               dior_n,
  output logic               diow_n,
  output logic [DEV_W-1:0]   dd_o,
  output logic               dd_oe
);
  localparam int HALF = DEV_W / 2;

  phase_t             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  acc_t               cur_q, cur_d;
  logic [ACT_W-1:0]   act_q, act_d;
  logic [REC_W-1:0]   rec_q, rec_d;
  logic               rdy_q, rdy_d, swap_q, swap_d;
  logic               ready, on_bus;
  logic [DEV_W-1:0]   out_word, in_word;

  function automatic logic [CNT_W-1:0] load(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign ready = !rdy_q || iordy_s;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    act_d  = act_q;
    rec_d  = rec_q;
    rdy_d  = rdy_q;
    swap_d = swap_q;
    case (ph_q)
      PH_IDLE: if (go) begin
        ph_d   = PH_SETUP;
        cnt_d  = load(CNT_W'(t_setup));
        cur_d  = head;
        act_d  = t_act;
        rec_d  = t_rec;
        rdy_d  = rdy_en;
        swap_d = swap_en;
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_ACTIVE;
          cnt_d = load(CNT_W'(act_q));
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_ACTIVE: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (ready) begin
          ph_d  = PH_RECOVER;
          cnt_d = load(CNT_W'(rec_q));
        end
      end
      default: begin
        if (cnt_q == '0) ph_d = PH_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      cur_q  <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      rdy_q  <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      cur_q  <= cur_d;
      act_q  <= act_d;
      rec_q  <= rec_d;
      rdy_q  <= rdy_d;
      swap_q <= swap_d;
    end
  end

  assign on_bus   = (ph_q == PH_SETUP) || (ph_q == PH_ACTIVE);
  assign out_word = (cur_q.wide && swap_q) ? {cur_q.wd[HALF-1:0], cur_q.wd[DEV_W-1:HALF]}
                                           : cur_q.wd;
  assign in_word  = !cur_q.wide ? {{HALF{1'b0}}, dd_i[HALF-1:0]} :
                    swap_q ? {dd_i[HALF-1:0], dd_i[DEV_W-1:HALF]} : dd_i;

  assign cs0_n     = !(on_bus && !cur_q.alt);
  assign cs1_n     = !(on_bus && cur_q.alt);
  assign da        = on_bus ? cur_q.da : 3'd0;
  assign dior_n    = !((ph_q == PH_ACTIVE) && cur_q.rd);
  assign diow_n    = !((ph_q == PH_ACTIVE) && !cur_q.rd);
  assign dd_oe     = on_bus && !cur_q.rd;
  assign dd_o      = dd_oe ? out_word : '0;
  assign cap_valid = (ph_q == PH_ACTIVE) && (cnt_q == '0) && ready && cur_q.rd;
  assign cap_data  = in_word;
  assign done      = (ph_q == PH_RECOVER) && (cnt_q == '0);
endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CPU_W-1:0]  cpu_wdata,
  output logic [CPU_W-1:0]  cpu_rdata,
  output logic              irq,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DEV_W-1:0]  ata_dd_o,
  output logic              ata_dd_oe,
  input  logic [DEV_W-1:0]  ata_dd_i,
  input  logic              ata_iordy,
  input  logic              ata_intrq
);
  logic [1:0]         rst_pipe_q;
  logic               rst_i_n;
  logic [1:0]         sync_q;
  logic               go, done, cap_valid, rdy_en, swap_en, ctrl_en;
  logic [DEV_W-1:0]   cap_data;
  acc_t               head;
  logic [SETUP_W-1:0] t_setup;
  logic [ACT_W-1:0]   t_act;
  logic [REC_W-1:0]   t_rec;
  logic [BUSY_W-1:0]  busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  ata_pio_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({ata_iordy, ata_intrq}), .q(sync_q)
  );

  ata_pio_regs u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .intrq_s(sync_q[0]), .done(done), .cap_valid(cap_valid), .cap_data(cap_data),
    .go(go), .head(head), .t_setup(t_setup), .t_act(t_act), .t_rec(t_rec),
    .rdy_en(rdy_en), .swap_en(swap_en), .en(ctrl_en), .busy_cnt(busy_cnt), .irq(irq)
  );

  ata_pio_engine u_eng (
    .clk(clk), .rst_n(rst_i_n), .go(go), .head(head),
    .t_setup(t_setup), .t_act(t_act), .t_rec(t_rec),
    .rdy_en(rdy_en), .swap_en(swap_en), .iordy_s(sync_q[1]), .dd_i(ata_dd_i),
    .done(done), .cap_valid(cap_valid), .cap_data(cap_data),
    .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n), .da(ata_da),
    .dior_n(ata_dior_n), .diow_n(ata_diow_n), .dd_o(ata_dd_o), .dd_oe(ata_dd_oe)
  );
endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs0_n,
  input logic       cs1_n,
  input logic       dior_n,
  input logic       diow_n,
  input logic       dd_oe,
  input logic [3:0] busy_cnt,
  input logic       en
);
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> $countones({!cs0_n, !cs1_n}) == 1);

  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> dior_n);

  a_r9_busy_limit: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 4'd2);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt == 4'd0) |-> (cs0_n && cs1_n && dior_n && diow_n));

  a_r8_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs0_n) || $fell(cs1_n)) |-> $past(en));
endmodule

bind ata_pio_host ata_pio_host_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n),
  .dior_n(ata_dior_n), .diow_n(ata_diow_n), .dd_oe(ata_dd_oe),
  .busy_cnt(busy_cnt), .en(ctrl_en)
);

// File: tb/tb_ata_pio_host.sv
module tb_ata_pio_host;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_TIME = 8'h08,
                         A_ISTAT = 8'h0C, A_IMASK = 8'h10, A_STAT = 8'h14, A_RDAT = 8'h18;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_sel, cpu_wr;
  logic [7:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic irq, cs0_n, cs1_n, dior_n, diow_n, dd_oe, iordy, intrq;
  logic [2:0]  da;
  logic [15:0] dd_o, dd_i;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_host dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .ata_cs0_n(cs0_n), .ata_cs1_n(cs1_n), .ata_da(da), .ata_dior_n(dior_n),
    .ata_diow_n(diow_n), .ata_dd_o(dd_o), .ata_dd_oe(dd_oe), .ata_dd_i(dd_i),
    .ata_iordy(iordy), .ata_intrq(intrq)
  );

  function automatic logic [7:0] win(input int k);
    return 8'(8'h40 + 4 * k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  // Follows one bus cycle while polling the busy field.
  task automatic measure(output int s, output int a, output int r,
                         output logic [15:0] dv, output logic [2:0] dav,
                         output logic c0, output logic c1, output logic oe);
    int g;
    logic [3:0] b0;
    s = 0; a = 0; r = 0; g = 0;
    dv = '0; dav = '0; c0 = 1'b1; c1 = 1'b1; oe = 1'b0;
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = A_STAT;
    @(negedge clk);
    while (cs0_n && cs1_n && g < 100) begin @(negedge clk); g++; end
    while (dior_n && diow_n && g < 200) begin s++; @(negedge clk); g++; end
    dv = dd_o; dav = da; c0 = cs0_n; c1 = cs1_n; oe = dd_oe;
    b0 = cpu_rdata[31:28];
    while ((!dior_n || !diow_n) && g < 400) begin a++; @(negedge clk); g++; end
    while (cpu_rdata[31:28] == b0 && g < 500) begin r++; @(negedge clk); g++; end
    cpu_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 strobes/selects", {28'd0, dior_n, diow_n, cs0_n, cs1_n}, 32'hF);
    check("R1 oe/irq", {30'd0, dd_oe, irq}, 32'd0);
    rd(A_STAT, d); check("R1 busy", d, 32'd0);
    rd(A_RDAT, d); check("R1 rdata", d, 32'd0);
  endtask

  task automatic t_timing(input int t1, input int t2, input int tr);
    int s, a, r; logic [15:0] dv; logic [2:0] dav; logic c0, c1, oe;
    wr(A_TIME, 32'((tr << 12) | (t2 << 4) | t1));
    wr(win(3), 32'h5A);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R2 setup", s, (t1 == 0) ? 1 : t1);
    check("R2 active", a, (t2 == 0) ? 1 : t2);
    check("R2 recovery", r, (tr == 0) ? 1 : tr);
    check("R3 address", dav, 3'd3);
  endtask

  task automatic t_writes;
    int s, a, r; logic [15:0] dv; logic [2:0] dav; logic c0, c1, oe;
    logic [31:0] d;
    wr(A_TIME, 32'hFFFF_FFFF);
    rd(A_TIME, d); check("R2 time readback", d, 32'h000F_FFFF);
    wr(A_TIME, 32'h2032);
    wr(win(1), 32'hFFFF_ABCD);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R4 byte write data", dv, 16'h00CD);
    check("R4 byte write oe", oe, 1'b1);
    check("R3 feature select", {c0, c1, dav}, {1'b0, 1'b1, 3'd1});
    wr(win(8), 32'h0E);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R3 control select", {c0, c1, dav}, {1'b1, 1'b0, 3'd6});
    check("R4 control data", dv, 16'h000E);
    wr(win(0), 32'hFFFF_1234);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R4 word write", dv, 16'h1234);
    check("R3 data select", {c0, c1, dav}, {1'b0, 1'b1, 3'd0});
  endtask

  task automatic t_reads;
    int s, a, r; logic [15:0] dv; logic [2:0] dav; logic c0, c1, oe;
    logic [31:0] d;
    dd_i = 16'hBEEF;
    rd(win(0), d); check("R5 window read returns 0", d, 32'd0);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R5 read oe low", oe, 1'b0);
    rd(A_RDAT, d); check("R5 word read", d, 32'h0000_BEEF);
    dd_i = 16'hBE50;
    rd(win(7), d);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R3 status address", dav, 3'd7);
    rd(A_RDAT, d); check("R5 byte read", d, 32'h0000_0050);
  endtask

  task automatic t_swap;
    int s, a, r; logic [15:0] dv; logic [2:0] dav; logic c0, c1, oe;
    logic [31:0] d;
    wr(A_CFG, 32'h40);
    wr(win(0), 32'h1234);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R6 swapped write", dv, 16'h3412);
    wr(win(2), 32'h77);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R6 byte write unswapped", dv, 16'h0077);
    dd_i = 16'hBEEF;
    rd(win(0), d);
    measure(s, a, r, dv, dav, c0, c1, oe);
    rd(A_RDAT, d); check("R6 swapped read", d, 32'h0000_EFBE);
    dd_i = 16'hBE50;
    rd(win(5), d);
    measure(s, a, r, dv, dav, c0, c1, oe);
    rd(A_RDAT, d); check("R6 byte read unswapped", d, 32'h0000_0050);
    wr(A_CFG, 32'h0);
  endtask

  task automatic t_iordy;
    int s, a, r; logic [15:0] dv; logic [2:0] dav; logic c0, c1, oe;
    wr(A_TIME, 32'h2032);
    iordy = 1'b0;
    wr(win(4), 32'h11);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R7 ignored when disabled", a, 3);
    wr(A_CFG, 32'h2);
    wr(win(4), 32'h22);
    fork
      measure(s, a, r, dv, dav, c0, c1, oe);
      begin
        @(negedge clk);
        while (diow_n) @(negedge clk);
        repeat (15) @(negedge clk);
        iordy = 1'b1;
      end
    join
    n_chk++;
    if (a < 16 || a > 20) begin
      n_bad++;
      $display("FAIL R7 stretched active actual=%0d expected=16..20", a);
    end
    wr(A_CFG, 32'h0);
  endtask

  task automatic t_enable_queue;
    int s, a, r; logic [15:0] dv; logic [2:0] dav; logic c0, c1, oe;
    logic [31:0] d;
    int strobes;
    wr(A_CTRL, 32'h0);
    wr(win(2), 32'hA1);
    strobes = 0;
    repeat (10) begin @(negedge clk); if (!diow_n || !cs0_n) strobes++; end
    check("R8 no cycle while disabled", strobes, 0);
    rd(A_STAT, d); check("R9 busy one", d[31:28], 4'd1);
    wr(win(3), 32'hB2);
    wr(win(4), 32'hC3);
    rd(A_STAT, d); check("R10 busy two, third dropped", d[31:28], 4'd2);
    wr(A_CTRL, 32'h1);
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R8/R10 first runs", {dav, dv}, {3'd2, 16'h00A1});
    measure(s, a, r, dv, dav, c0, c1, oe);
    check("R10 second runs", {dav, dv}, {3'd3, 16'h00B2});
    strobes = 0;
    repeat (20) begin @(negedge clk); if (!diow_n) strobes++; end
    check("R10 third discarded", strobes, 0);
    rd(A_STAT, d); check("R9 busy zero", d[31:28], 4'd0);
  endtask

  task automatic t_intr;
    logic [31:0] d;
    intrq = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_ISTAT, d); check("R11 edge sets status", d, 32'd1);
    check("R12 masked off", irq, 1'b0);
    wr(A_IMASK, 32'h1);
    check("R12 unmasked", irq, 1'b1);
    wr(A_ISTAT, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_ISTAT, d); check("R11 cleared, level no re-set", d, 32'd0);
    check("R12 irq after clear", irq, 1'b0);
    intrq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    dd_i = '0; iordy = 1'b1; intrq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    wr(A_CTRL, 32'h1);
    t_timing(2, 3, 2);
    t_timing(5, 10, 4);
    t_timing(0, 0, 0);
    t_writes();
    t_reads();
    t_swap();
    t_iordy();
    t_enable_queue();
    t_intr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule